// File: doc/BRIEF.md
# DMA transfer address generator

This block turns per-transfer access requests from peripherals into physical memory addresses for a four-channel DMA controller. A peripheral raises a one-cycle request strobe naming a channel and a direction: either data goes into memory or data comes out of memory. The block checks the request against that channel's programmed transfer kind and mask. It then either rejects the request or accepts it. An accepted request returns the channel's current 24-bit physical address and steps the channel's 16-bit address and count.

The upper address byte comes from a bank of eight page bytes. An 8-bit bus writes and reads them through page port indices. The indices land in storage slots in a fixed scrambled order, and channel n takes its page from slot n. The end-of-process output marks the single access on which a channel's count wraps from zero to 0xFFFF. An external complete input can force a channel's terminal-count state. A load port programs one channel at a time. Data movement, reload after completion and arbitration between channels belong to other blocks.

Top module: `dma_agen`

## Requirements
- R1: A request is accepted only when the channel's transfer kind matches the direction. Kind 2'b01 with req_to_mem=1 is accepted, and kind 2'b10 with req_to_mem=0 is accepted. Kinds 2'b00 and 2'b11 never accept. A rejected request leaves the channel's address, count and terminal-count state unchanged.
- R2: A request on a channel whose mask bit is set is rejected, whatever its kind, and leaves the channel state unchanged.
- R3: Each request strobe yields exactly one response, with rsp_valid high in the following cycle. A rejection reports rsp_accept=0, rsp_addr=0 and rsp_eop=0.
- R4: An accepted request reports the channel's current 16-bit address in rsp_addr[15:0]. The channel address then steps by +1, or by -1 when the channel's down bit is set, wrapping modulo 2^16.
- R5: Every accepted request decrements the channel's 16-bit count modulo 2^16. The channel's terminal-count state becomes set when the decremented count equals 0xFFFF, and it stays set until the channel is loaded again.
- R6: rsp_eop is 1 only on the accepted access that moves terminal-count from clear to set. Every other response carries rsp_eop=0, including later wraps.
- R7: rsp_addr[23:16] of an accepted response holds the page byte in storage slot n, where n is the requesting channel.
- R8: A page write with pg_we=1 stores pg_wdata in a slot chosen from pg_idx. Indices 7,3,1,2,0,4,5,6 select slots 0,1,2,3,4,5,6,7 respectively. pg_rdata returns the slot selected by pg_idx through the same mapping.
- R9: A pulse on done_set[n] sets channel n's terminal-count state, so no later wrap on that channel raises rsp_eop.
- R10: A load with ld_valid=1 writes address, count, kind, down and mask into channel ld_chan and clears its terminal-count state. After reset, every channel is masked with kind 2'b00, every page byte is 0, and rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle access request strobe |
| req_chan | input | 2 | Requesting channel |
| req_to_mem | input | 1 | 1: data into memory, 0: data out of memory |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_accept | output | 1 | Request accepted |
| rsp_addr | output | 24 | Physical address {page, channel address}; 0 on reject |
| rsp_eop | output | 1 | Completing access marker |
| ld_valid | input | 1 | Channel load strobe |
| ld_chan | input | 2 | Channel to load |
| ld_addr | input | 16 | Start address |
| ld_count | input | 16 | Start count |
| ld_kind | input | 2 | Transfer kind (00 check, 01 into memory, 10 out of memory, 11 unused) |
| ld_down | input | 1 | Address steps downward |
| ld_mask | input | 1 | Channel masked |
| done_set | input | 4 | Per-channel force of terminal-count |
| pg_we | input | 1 | Page byte write enable |
| pg_idx | input | 3 | Page port index |
| pg_wdata | input | 8 | Page byte write data |
| pg_rdata | output | 8 | Page byte at pg_idx |

## Verification
The hardest case to reach from the ports is the second wrap of a channel's count. It must produce no end-of-process, both after a natural completion and after a forced one. The stimulus loads a channel with count zero and keeps requesting past 0xFFFF. It also pulses done_set before the count runs out, so the one wrap that follows has to stay silent. A rejected request in the middle of a run is shown to be harmless by the address that the next accepted request returns.

// File: rtl/dma_agen_pkg.sv
// Shared types and the page index mapping for the DMA address generator.
// Assumes eight page slots and a 3-bit page port index.
package dma_agen_pkg;

    typedef enum logic [1:0] {
        XFER_CHECK    = 2'b00,
        XFER_TO_MEM   = 2'b01,
        XFER_FROM_MEM = 2'b10,
        XFER_UNUSED   = 2'b11
    } xfer_e;

    // Storage slot selected by a page port index.
    function automatic logic [2:0] page_slot(input logic [2:0] idx);
        case (idx)
            3'd7:    page_slot = 3'd0;
            3'd3:    page_slot = 3'd1;
            3'd1:    page_slot = 3'd2;
            3'd2:    page_slot = 3'd3;
            3'd0:    page_slot = 3'd4;
            3'd4:    page_slot = 3'd5;
            3'd5:    page_slot = 3'd6;
            default: page_slot = 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/dma_agen_page_store.sv
// Eight page bytes behind a scrambled index-to-slot mapping.
// The bus side reads and writes through the mapping.
// Channel n reads slot n directly. Assumes NCH <= 8.
module dma_agen_page_store
    import dma_agen_pkg::*;
#(
    parameter int PW  = 8,
    parameter int NCH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [2:0]          idx,
    input  logic [PW-1:0]       wdata,
    output logic [PW-1:0]       rdata,
    output logic [NCH*PW-1:0]   chan_page
);
    localparam int NSLOT = 8;

    logic [PW-1:0] slot_q [NSLOT];
    logic [2:0]    sel;

    // Index remap shared by read and write.
    always_comb sel = page_slot(idx);

    // Slot storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
        end else if (we) begin
            slot_q[sel] <= wdata;
        end
    end

    // Bus read port.
    always_comb rdata = slot_q[sel];

    // Direct slot-per-channel taps.
    for (genvar c = 0; c < NCH; c++) begin : g_tap
        assign chan_page[c*PW +: PW] = slot_q[c];
    end

    // R8: a write lands in the mapped slot.
    a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> slot_q[$past(sel)] == $past(wdata));

endmodule

// File: rtl/dma_agen_channel.sv
// State of one DMA channel: address, count, kind, direction of stepping,
// mask and terminal-count. It decides acceptance for a request,
// combinationally, and steps its state on an accepted hit.
// A load takes priority over any other update in the same cycle.
module dma_agen_channel
    import dma_agen_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [AW-1:0] ld_count,
    input  xfer_e         ld_kind,
    input  logic          ld_down,
    input  logic          ld_mask,
    input  logic          hit,
    input  logic          to_mem,
    input  logic          done_i,
    output logic          grant,
    output logic [AW-1:0] cur_addr,
    output logic          eop_next
);
    logic [AW-1:0] addr_q, count_q, count_dec;
    xfer_e         kind_q;
    logic          down_q, mask_q, tc_q, wrap;

    // Acceptance: unmasked and kind matches direction.
    always_comb begin
        grant = !mask_q &&
                ((kind_q == XFER_TO_MEM && to_mem) ||
                 (kind_q == XFER_FROM_MEM && !to_mem));
    end

    // Count after this access and the completion transition it causes.
    always_comb begin
        count_dec = count_q - AW'(1);
        wrap      = (count_dec == {AW{1'b1}});
        eop_next  = !tc_q && wrap;
        cur_addr  = addr_q;
    end

    // Channel state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            count_q <= '0;
            kind_q  <= XFER_CHECK;
            down_q  <= 1'b0;
            mask_q  <= 1'b1;
            tc_q    <= 1'b0;
        end else if (ld_en) begin
            addr_q  <= ld_addr;
            count_q <= ld_count;
            kind_q  <= ld_kind;
            down_q  <= ld_down;
            mask_q  <= ld_mask;
            tc_q    <= 1'b0;
        end else begin
            if (hit && grant) begin
                addr_q  <= down_q ? addr_q - AW'(1) : addr_q + AW'(1);
                count_q <= count_dec;
            end
            if ((hit && grant && wrap) || done_i) tc_q <= 1'b1;
        end
    end

    // R1, R2: a rejected hit leaves address and count alone.
    a_r1_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !grant && !ld_en) |=> ($stable(addr_q) && $stable(count_q)));

    // R4: accepted hit steps the address by one in the chosen direction.
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && grant && !ld_en) |=>
        (addr_q == ($past(down_q) ? $past(addr_q) - AW'(1) : $past(addr_q) + AW'(1))));

    // R5: terminal-count is sticky until a load.
    a_r5_tc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_q && !ld_en) |=> tc_q);

    // R9: forced completion sets terminal-count.
    a_r9_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !ld_en) |=> tc_q);

endmodule

// File: rtl/dma_agen.sv
// DMA transfer address generator top. It routes a request to its channel,
// registers the accept/reject result, the 24-bit physical address and the
// end-of-process marker one cycle later, and hosts the page byte store.
// Assumes req_valid is a single-cycle strobe.
module dma_agen
    import dma_agen_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int PW  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [$clog2(NCH)-1:0]   req_chan,
    input  logic                     req_to_mem,
    output logic                     rsp_valid,
    output logic                     rsp_accept,
    output logic [PW+AW-1:0]         rsp_addr,
    output logic                     rsp_eop,
    input  logic                     ld_valid,
    input  logic [$clog2(NCH)-1:0]   ld_chan,
    input  logic [AW-1:0]            ld_addr,
    input  logic [AW-1:0]            ld_count,
    input  logic [1:0]               ld_kind,
    input  logic                     ld_down,
    input  logic                     ld_mask,
    input  logic [NCH-1:0]           done_set,
    input  logic                     pg_we,
    input  logic [2:0]               pg_idx,
    input  logic [PW-1:0]            pg_wdata,
    output logic [PW-1:0]            pg_rdata
);
    localparam int PA = PW + AW;

    logic [NCH-1:0]    grant_v, eop_v;
    logic [AW-1:0]     addr_v [NCH];
    logic [NCH*PW-1:0] chan_page;

    dma_agen_page_store #(.PW(PW), .NCH(NCH)) u_pages (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (pg_we),
        .idx       (pg_idx),
        .wdata     (pg_wdata),
        .rdata     (pg_rdata),
        .chan_page (chan_page)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dma_agen_channel #(.AW(AW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_en    (ld_valid && (ld_chan == c)),
            .ld_addr  (ld_addr),
            .ld_count (ld_count),
            .ld_kind  (xfer_e'(ld_kind)),
            .ld_down  (ld_down),
            .ld_mask  (ld_mask),
            .hit      (req_valid && (req_chan == c)),
            .to_mem   (req_to_mem),
            .done_i   (done_set[c]),
            .grant    (grant_v[c]),
            .cur_addr (addr_v[c]),
            .eop_next (eop_v[c])
        );
    end

    // Registered response for the strobed channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_accept <= 1'b0;
            rsp_addr   <= '0;
            rsp_eop    <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_accept <= req_valid && grant_v[req_chan];
            rsp_eop    <= req_valid && grant_v[req_chan] && eop_v[req_chan];
            if (req_valid && grant_v[req_chan])
                rsp_addr <= {chan_page[req_chan*PW +: PW], addr_v[req_chan]};
            else
                rsp_addr <= '0;
        end
    end

    // R3: one response per strobe, none without.
    a_r3_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R6: end-of-process only with acceptance.
    a_r6_eop_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_eop |-> (rsp_valid && rsp_accept));

    // R3: a rejection carries a zero address.
    a_r3_reject_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_accept) |-> (rsp_addr == PA'(0)));

endmodule

// File: tb/dma_agen_bench.sv
// Scoreboard bench for dma_agen. The driver pushes model expectations and
// a negedge monitor pops them against the registered responses.
module dma_agen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_chan = '0;
    logic        req_to_mem = 1'b0;
    logic        rsp_valid, rsp_accept, rsp_eop;
    logic [23:0] rsp_addr;
    logic        ld_valid = 1'b0;
    logic [1:0]  ld_chan = '0;
    logic [15:0] ld_addr = '0, ld_count = '0;
    logic [1:0]  ld_kind = '0;
    logic        ld_down = 1'b0, ld_mask = 1'b0;
    logic [3:0]  done_set = '0;
    logic        pg_we = 1'b0;
    logic [2:0]  pg_idx = '0;
    logic [7:0]  pg_wdata = '0;
    logic [7:0]  pg_rdata;

    always #4 clk = ~clk;

    dma_agen u_dma_agen (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_chan(req_chan), .req_to_mem(req_to_mem),
        .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .rsp_addr(rsp_addr), .rsp_eop(rsp_eop),
        .ld_valid(ld_valid), .ld_chan(ld_chan), .ld_addr(ld_addr), .ld_count(ld_count),
        .ld_kind(ld_kind), .ld_down(ld_down), .ld_mask(ld_mask),
        .done_set(done_set),
        .pg_we(pg_we), .pg_idx(pg_idx), .pg_wdata(pg_wdata), .pg_rdata(pg_rdata)
    );

    typedef struct {
        logic [25:0] v;   // {accept, addr, eop}
        string       tag;
    } exp_t;
    exp_t q[$];

    int n_chk = 0, n_bad = 0;
    bit done_flag = 0;

    // Reference model built from the requirements.
    logic [15:0] m_addr [4];
    logic [15:0] m_cnt  [4];
    logic [1:0]  m_kind [4];
    bit          m_down [4], m_mask [4], m_tc [4];
    logic [7:0]  m_slot [8];
    int          slot_of [8] = '{4, 2, 3, 1, 5, 6, 7, 0};  // R8 index->slot

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_req(int c, bit to_mem, string tag);
        exp_t e;
        bit acc;
        logic [15:0] nc;
        bit eop;
        acc = !m_mask[c] && ((m_kind[c] == 2'b01 && to_mem) || (m_kind[c] == 2'b10 && !to_mem));
        eop = 0;
        if (acc) begin
            nc  = m_cnt[c] - 16'd1;
            eop = !m_tc[c] && (nc == 16'hFFFF);
            e.v = {1'b1, m_slot[c], m_addr[c], eop};
            m_addr[c] = m_down[c] ? m_addr[c] - 16'd1 : m_addr[c] + 16'd1;
            m_cnt[c]  = nc;
            if (nc == 16'hFFFF) m_tc[c] = 1;
        end else begin
            e.v = {1'b0, 24'h0, 1'b0};
        end
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_chan = 2'(c); req_to_mem = to_mem;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic load(int c, logic [15:0] a, logic [15:0] n, logic [1:0] k, bit dn, bit mk);
        @(negedge clk);
        ld_valid = 1'b1; ld_chan = 2'(c); ld_addr = a; ld_count = n;
        ld_kind = k; ld_down = dn; ld_mask = mk;
        @(negedge clk);
        ld_valid = 1'b0;
        m_addr[c] = a; m_cnt[c] = n; m_kind[c] = k; m_down[c] = dn; m_mask[c] = mk; m_tc[c] = 0;
    endtask

    task automatic page_wr(int idx, logic [7:0] d);
        @(negedge clk);
        pg_we = 1'b1; pg_idx = 3'(idx); pg_wdata = d;
        @(negedge clk);
        pg_we = 1'b0;
        m_slot[slot_of[idx]] = d;
    endtask

    task automatic pulse_done(int c);
        @(negedge clk);
        done_set = 4'(1 << c);
        @(negedge clk);
        done_set = '0;
        m_tc[c] = 1;
    endtask

    // Monitor: compare each response against the queue head.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) begin
                check("R3 unexpected response", 32'(rsp_valid), 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, 32'({rsp_accept, rsp_addr, rsp_eop}), 32'(e.v));
            end
        end
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int c = 0; c < 4; c++) begin
            m_addr[c] = 0; m_cnt[c] = 0; m_kind[c] = 0; m_down[c] = 0; m_mask[c] = 1; m_tc[c] = 0;
        end
        for (int s = 0; s < 8; s++) m_slot[s] = 0;
        repeat (3) @(negedge clk);
        // R10: reset state.
        check("R10 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        for (int i = 0; i < 8; i++) begin
            pg_idx = 3'(i);
            #1 check("R10 page byte after reset", 32'(pg_rdata), 32'd0);
        end
        rst_n = 1'b1;
        // R2, R10: channel masked after reset.
        do_req(0, 1, "R2 masked after reset");
        // R8: page writes and readback through the mapping.
        for (int i = 0; i < 8; i++) page_wr(i, 8'hA0 + 8'(i));
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            pg_idx = 3'(i);
            #1 check("R8 page readback", 32'(pg_rdata), 32'(8'hA0 + 8'(i)));
        end
        // R4, R5, R6, R7: upward run on channel 0, page from index 7.
        load(0, 16'h1000, 16'd2, 2'b01, 0, 0);
        do_req(0, 1, "R4 first address");
        do_req(0, 1, "R5 count step");
        do_req(0, 0, "R1 direction mismatch");
        do_req(0, 1, "R6 eop on wrap");
        do_req(0, 1, "R6 no eop after wrap");
        // R4, R6: downward run with address wrap on channel 1.
        load(1, 16'h0001, 16'd0, 2'b10, 1, 0);
        do_req(1, 0, "R6 eop count zero");
        do_req(1, 0, "R4 down step");
        do_req(1, 0, "R4 down wrap");
        do_req(1, 1, "R1 read kind rejects write");
        // R1: check and unused kinds never accept.
        load(2, 16'h2222, 16'd5, 2'b00, 0, 0);
        do_req(2, 1, "R1 check kind");
        do_req(2, 0, "R1 check kind");
        load(2, 16'h2222, 16'd5, 2'b11, 0, 0);
        do_req(2, 1, "R1 unused kind");
        do_req(2, 0, "R1 unused kind");
        load(2, 16'h2222, 16'd5, 2'b01, 0, 0);
        do_req(2, 1, "R7 channel 2 page");
        // R2: masked load rejects, unmask accepts.
        load(3, 16'h3000, 16'd1, 2'b01, 0, 1);
        do_req(3, 1, "R2 masked channel");
        load(3, 16'h3000, 16'd1, 2'b01, 0, 0);
        // R9: forced completion silences the wrap.
        pulse_done(3);
        do_req(3, 1, "R9 after done");
        do_req(3, 1, "R9 wrap without eop");
        // R10: reload clears terminal-count.
        load(3, 16'h3100, 16'd0, 2'b01, 0, 0);
        do_req(3, 1, "R10 reload restores eop");
        // R3: back-to-back responses drain.
        repeat (4) @(negedge clk);
        check("R3 queue drained", 32'(q.size()), 32'd0);
        finish_run();
    end
endmodule